// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block turns activity on an eight-pin general-purpose I/O port into interrupt status. Each pin can be set to fire on a rising edge, a falling edge, any change, a high level or a low level. Three per-pin control vectors make the choice: one picks edge or level, one picks polarity, and one makes an edge pin fire on either direction. Edges are found by comparing the already-synchronized pin vector with a registered copy taken on the previous clock. Edge detection applies only to pins configured as inputs.

Detected events set bits in a sticky raw status register. A bit stays set until software clears it by writing a one to it through a write-one-to-clear port. The block also offers a masked view of the status and one combined interrupt line. A level-sensitive pin sets its bit again on every clock while its level stays active, so clearing that bit has no lasting effect until the level goes away. The register decoder, the configuration registers and the input synchronizers are outside this block.

Top module: `gpio_irq_detect`

## Requirements
- R1: While `rstN` is low and on the first sample after it rises, `rawStatus`, `maskedStatus` and `irqOut` are all zero. The previous-value register also resets to zero.
- R2: Bit i of every vector belongs to pin i. For an edge pin (sense bit 0, both-edges bit 0), a change of `pinIn[i]` between two clocks sets `rawStatus[i]` after that clock only when the new value equals `eventCfg[i]`. Event bit 1 selects rising edges and event bit 0 selects falling edges.
- R3: For an edge pin whose `bothEdgeCfg[i]` is 1, any change of `pinIn[i]` sets `rawStatus[i]`, whatever the value of `eventCfg[i]`.
- R4: A pin whose `pinDir[i]` is 1 (output) never sets its status bit through edge detection.
- R5: For a level pin (`senseCfg[i]` = 1), `rawStatus[i]` is set after every clock on which `pinIn[i]` equals `eventCfg[i]`, whatever the pin's direction. A clear of that bit while the level persists leaves it set.
- R6: `maskedStatus` equals `rawStatus & maskCfg`, and `irqOut` is 1 exactly when `maskedStatus` is nonzero. Both follow `rawStatus` and `maskCfg` with no extra register.
- R7: A clock with `clrEn` high clears each status bit where `clrData` has a 1 and leaves the bits with a 0 unchanged.
- R8: If a clear and a new event hit the same bit on the same clock, the bit ends up set.
- R9: A status bit, once set, stays set after the triggering condition goes away until it is cleared or the block is reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pinIn | input | 8 | Synchronized pin values |
| pinDir | input | 8 | Pin direction, 1 = output |
| senseCfg | input | 8 | 0 = edge-sensitive, 1 = level-sensitive |
| bothEdgeCfg | input | 8 | 1 = edge pin fires on any change |
| eventCfg | input | 8 | Polarity: 1 = rising or high, 0 = falling or low |
| maskCfg | input | 8 | Interrupt enable for each pin |
| clrEn | input | 1 | Strobe for a write-one-to-clear |
| clrData | input | 8 | Status bits to clear |
| rawStatus | output | 8 | Sticky raw status |
| maskedStatus | output | 8 | Raw status AND mask |
| irqOut | output | 1 | Combined interrupt line |

## Verification
A stale previous-value register shows up as an edge that never appears, or that appears a clock late or on the wrong pin, and it is visible in `rawStatus` at the first sample after the clock that should have caught it. A wrong merge of set and clear shows up in the same sample: a bit that survives its clear, a bit lost to a clear that races an event, or an unrelated bit dropped. Polarity, both-edge and direction gating are covered by a run of table rows in which each row changes one condition, so each fault reaches the ports within one clock and is attributed to a single requirement. Mask and interrupt errors are combinational and show at the very sample where the status is checked.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // Port width of the detector; all vectors are indexed by pin number.
  localparam int unsigned PinCount = 8;

  typedef logic [PinCount-1:0] pinVec_t;

  // Strobes from the detection control to the status datapath.
  typedef struct packed {
    pinVec_t setVec;  // pins with an event this cycle
    pinVec_t clrVec;  // pins written with one on the clear port
  } statusStrobe_t;

endpackage

// File: rtl/gpio_irq_pin_cell.sv
module gpio_irq_pin_cell (
  input  logic clk,
  input  logic rstN,
  input  logic pinNow,
  input  logic pinPrev,
  input  logic isOutput,
  input  logic levelMode,
  input  logic anyEdge,
  input  logic polarity,
  output logic eventHit
);

  logic changed;
  logic matchPol;
  logic edgeHit;
  logic levelHit;

  always_comb begin
    changed  = (pinNow ^ pinPrev) & ~isOutput;
    matchPol = ~(pinNow ^ polarity);
    edgeHit  = ~levelMode & changed & (anyEdge | matchPol);
    levelHit = levelMode & matchPol;
    eventHit = edgeHit | levelHit;
  end

  // R4
  out_pin_no_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isOutput && !levelMode) |-> !eventHit);

  // R3
  any_edge_fires_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!levelMode && anyEdge && !isOutput && (pinNow != pinPrev)) |-> eventHit);

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  pinVec_t       pinIn,
  input  pinVec_t       prevIn,
  input  pinVec_t       pinDir,
  input  pinVec_t       senseCfg,
  input  pinVec_t       bothEdgeCfg,
  input  pinVec_t       eventCfg,
  input  logic          clrEn,
  input  pinVec_t       clrData,
  output statusStrobe_t strobe
);

  pinVec_t hitVec;

  for (genvar g = 0; g < PinCount; g++) begin : g_pin
    gpio_irq_pin_cell u_cell (
      .clk      (clk),
      .rstN     (rstN),
      .pinNow   (pinIn[g]),
      .pinPrev  (prevIn[g]),
      .isOutput (pinDir[g]),
      .levelMode(senseCfg[g]),
      .anyEdge  (bothEdgeCfg[g]),
      .polarity (eventCfg[g]),
      .eventHit (hitVec[g])
    );
  end

  always_comb begin
    strobe.setVec = hitVec;
    strobe.clrVec = clrEn ? clrData : '0;
  end

  // R7
  clear_only_when_enabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    !clrEn |-> (strobe.clrVec == '0));

endmodule

// File: rtl/gpio_irq_datapath.sv
module gpio_irq_datapath
  import gpio_irq_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  pinVec_t       pinIn,
  input  pinVec_t       maskCfg,
  input  statusStrobe_t strobe,
  output pinVec_t       prevIn,
  output pinVec_t       rawQ,
  output pinVec_t       maskedQ,
  output logic          irqAny
);

  pinVec_t rawNext;

  always_comb begin
    // Clear first, then set: an event in the same cycle wins.
    rawNext = (rawQ & ~strobe.clrVec) | strobe.setVec;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevIn <= '0;
      rawQ   <= '0;
    end else begin
      prevIn <= pinIn;
      rawQ   <= rawNext;
    end
  end

  always_comb begin
    maskedQ = rawQ & maskCfg;
    irqAny  = |maskedQ;
  end

  // R7
  cleared_bits_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((rawQ & $past(strobe.clrVec & ~strobe.setVec)) == '0));

  // R8
  set_bits_land_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((rawQ & $past(strobe.setVec)) == $past(strobe.setVec)));

  // R9
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((~rawQ & $past(rawQ & ~strobe.clrVec)) == '0));

  // R2
  prev_tracks_pin_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (prevIn == $past(pinIn)));

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [PinCount-1:0] pinIn,
  input  logic [PinCount-1:0] pinDir,
  input  logic [PinCount-1:0] senseCfg,
  input  logic [PinCount-1:0] bothEdgeCfg,
  input  logic [PinCount-1:0] eventCfg,
  input  logic [PinCount-1:0] maskCfg,
  input  logic                clrEn,
  input  logic [PinCount-1:0] clrData,
  output logic [PinCount-1:0] rawStatus,
  output logic [PinCount-1:0] maskedStatus,
  output logic                irqOut
);

  statusStrobe_t strobe;
  pinVec_t       prevIn;

  gpio_irq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .pinIn      (pinIn),
    .prevIn     (prevIn),
    .pinDir     (pinDir),
    .senseCfg   (senseCfg),
    .bothEdgeCfg(bothEdgeCfg),
    .eventCfg   (eventCfg),
    .clrEn      (clrEn),
    .clrData    (clrData),
    .strobe     (strobe)
  );

  gpio_irq_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .pinIn  (pinIn),
    .maskCfg(maskCfg),
    .strobe (strobe),
    .prevIn (prevIn),
    .rawQ   (rawStatus),
    .maskedQ(maskedStatus),
    .irqAny (irqOut)
  );

  // R6
  irq_matches_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == ((rawStatus & maskCfg) != '0));

endmodule

// File: tb/gpio_irq_detect_tb.sv
module gpio_irq_detect_tb;

  localparam int ClkPeriod = 10;
  localparam int NumRows   = 17;

  typedef struct packed {
    logic [7:0] pins;
    logic [7:0] dir;
    logic [7:0] sense;
    logic [7:0] both;
    logic [7:0] evt;
    logic [7:0] mask;
    logic       clrOn;
    logic [7:0] clr;
    logic [7:0] expRaw;
    logic       expIrq;
  } row_t;

  // Each row is applied for one clock and checked after it; state carries over.
  localparam row_t Rows [NumRows] = '{
    '{8'h01, 8'h00, 8'h00, 8'h00, 8'hFF, 8'h00, 1'b0, 8'h00, 8'h01, 1'b0}, // R2 rising
    '{8'h01, 8'h00, 8'h00, 8'h00, 8'hFF, 8'h01, 1'b0, 8'h00, 8'h01, 1'b1}, // R9 R6 held, masked
    '{8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 8'h01, 1'b1, 8'h01, 8'h00, 1'b0}, // R2 fall ignored, R7 clear
    '{8'h02, 8'h00, 8'h00, 8'h00, 8'h00, 8'h02, 1'b0, 8'h00, 8'h00, 1'b0}, // R2 rise ignored on falling pin
    '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h02, 1'b0, 8'h00, 8'h02, 1'b1}, // R2 falling
    '{8'h04, 8'h00, 8'h00, 8'h04, 8'h00, 8'h02, 1'b0, 8'h00, 8'h06, 1'b1}, // R3 rise on both-edge
    '{8'h00, 8'h00, 8'h00, 8'h04, 8'h00, 8'h02, 1'b1, 8'h04, 8'h06, 1'b1}, // R3 R8 fall beats clear
    '{8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 8'h02, 1'b1, 8'hFF, 8'h00, 1'b0}, // R7 clear all
    '{8'h08, 8'h08, 8'h00, 8'h00, 8'hFF, 8'hFF, 1'b0, 8'h00, 8'h00, 1'b0}, // R4 output pin rise
    '{8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 8'hFF, 1'b0, 8'h00, 8'h00, 1'b0}, // R2 fall on rising pin
    '{8'h10, 8'h00, 8'h10, 8'h00, 8'h10, 8'h10, 1'b0, 8'h00, 8'h10, 1'b1}, // R5 high level
    '{8'h10, 8'h00, 8'h10, 8'h00, 8'h10, 8'h10, 1'b1, 8'h10, 8'h10, 1'b1}, // R5 clear while active
    '{8'h00, 8'h00, 8'h10, 8'h00, 8'h10, 8'h10, 1'b1, 8'h10, 8'h00, 1'b0}, // R5 level gone, clear works
    '{8'h00, 8'h00, 8'h20, 8'h00, 8'h00, 8'h20, 1'b0, 8'h00, 8'h20, 1'b1}, // R5 low level
    '{8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 8'h20, 1'b1, 8'hFF, 8'h00, 1'b0}, // R7 clear
    '{8'h40, 8'h40, 8'h40, 8'h00, 8'h40, 8'h00, 1'b0, 8'h00, 8'h40, 1'b0}, // R5 level on output pin
    '{8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 8'h00, 1'b1, 8'hFF, 8'h00, 1'b0}  // R7 R2 cleanup
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] pinIn = '0, pinDir = '0, senseCfg = '0, bothEdgeCfg = '0;
  logic [7:0] eventCfg = '0, maskCfg = '0, clrData = '0;
  logic       clrEn = 1'b0;
  logic [7:0] rawStatus, maskedStatus;
  logic       irqOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(ClkPeriod/2) clk = ~clk;

  gpio_irq_detect u_dut (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .pinDir(pinDir),
    .senseCfg(senseCfg), .bothEdgeCfg(bothEdgeCfg), .eventCfg(eventCfg),
    .maskCfg(maskCfg), .clrEn(clrEn), .clrData(clrData),
    .rawStatus(rawStatus), .maskedStatus(maskedStatus), .irqOut(irqOut)
  );

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic checkOutputs(input string req, input logic [7:0] expRaw,
                              input logic [7:0] mask, input logic expIrq);
    check(req, "rawStatus", rawStatus, expRaw);
    check("R6", "maskedStatus", maskedStatus, expRaw & mask);
    check("R6", "irqOut", {7'b0, irqOut}, {7'b0, expIrq});
  endtask

  // Inputs change on the falling edge; outputs are sampled on the next one.
  task automatic stepCycle();
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    // R1 outputs quiet during reset
    checkOutputs("R1", 8'h00, 8'h00, 1'b0);
    rstN = 1'b1;
    stepCycle();
    checkOutputs("R1", 8'h00, 8'h00, 1'b0);

    for (int i = 0; i < NumRows; i++) begin
      pinIn       = Rows[i].pins;
      pinDir      = Rows[i].dir;
      senseCfg    = Rows[i].sense;
      bothEdgeCfg = Rows[i].both;
      eventCfg    = Rows[i].evt;
      maskCfg     = Rows[i].mask;
      clrEn       = Rows[i].clrOn;
      clrData     = Rows[i].clr;
      stepCycle();
      clrEn = 1'b0;
      checkOutputs($sformatf("row%0d", i), Rows[i].expRaw, Rows[i].mask, Rows[i].expIrq);
    end

    // R2 all pins rise together, all rising-sensitive
    eventCfg = 8'hFF; maskCfg = 8'h80; pinIn = 8'hFF;
    stepCycle();
    checkOutputs("R2", 8'hFF, 8'h80, 1'b1);

    // R7 partial clear keeps the other bits
    clrEn = 1'b1; clrData = 8'h0F;
    stepCycle();
    clrEn = 1'b0;
    checkOutputs("R7", 8'hF0, 8'h80, 1'b1);

    // R9 no further events: bits hold, clear data ignored without strobe
    clrData = 8'hFF;
    stepCycle();
    checkOutputs("R9", 8'hF0, 8'h80, 1'b1);

    // R6 mask change alone updates masked view and line in the same cycle
    #1 maskCfg = 8'h0F;
    #1 checkOutputs("R6", 8'hF0, 8'h0F, 1'b0);

    // R1 reset in mid-run clears the sticky status
    rstN = 1'b0;
    #1 checkOutputs("R1", 8'h00, 8'h0F, 1'b0);
    stepCycle();
    pinIn = 8'h00;
    rstN  = 1'b1;
    stepCycle();
    checkOutputs("R1", 8'h00, 8'h0F, 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule